// File: doc/BRIEF.md
# Ciphertext-Feedback Keystream Generator

This block generates a keystream for a bit-serial character cipher. It uses two nonlinear shift registers, called P and Q. Each ciphertext bit is shifted into P. The combining output of P, chosen by taps, feeds Q. The combining output of Q drives a toggle integrator, and the integrator state is the key bit. Plaintext XOR key gives ciphertext. Decryption uses the same structure: received ciphertext goes straight into P, so an encrypting instance and a decrypting instance loaded with the same fill stay in lockstep.

The operating mode is selected when the fill is loaded. In start-stop mode, P is one 47-stage chain and its taps may fall on any stage. Q has 24 stages, and 47 and 24 share no common factor. In synchronous mode, the first 17 stages of the chain act as a separate extension register that feeds a 30-stage main section. P's taps are confined to that main section, and the ciphertext bit is XORed with P's combining output before it enters Q. A single-cycle parallel load writes both register contents and all tap selectors, and clears the integrator.

The controller has two states. ST_BLANK is entered by reset: there is no fill yet, data is not accepted, and bits pass through unchanged. ST_KEYED is entered on the FILL transition (load_en high from either state). In ST_KEYED, the STEP transition (bit_valid high, load_en low) advances P, Q and the integrator, and the IDLE transition (neither input high) holds everything.

Top module: `feedback_keystream_gen`

## Requirements
- R1: After reset the block is in ST_BLANK: key_bit is 0, bit_valid is ignored and bit_out equals bit_in, until the first load.
- R2: A load takes one cycle and wins over bit_valid in the same cycle, whose bit is dropped. From the next cycle key_bit is 0. The fill_in layout is: bits 0..46 set P stages 0..46; bits 47..70 set Q stages 0..23; bits 71..94 hold four 6-bit P tap selectors, tap i at bit 71+6i; bits 95..114 hold four 5-bit Q tap selectors, tap i at bit 95+5i.
- R3: In ST_KEYED, bit_out equals bit_in XOR key_bit in the same cycle.
- R4: On each accepted bit, the ciphertext bit enters P stage 0 and every stage k moves to stage k+1. The ciphertext bit is bit_out when encrypting and bit_in when decrypting.
- R5: Each combining output is (t0 AND t1) OR (t2 AND t3), where ti is the stage picked by tap i. For P in start-stop mode, tap i is stage (sel_i mod 47). For P in synchronous mode, tap i is stage 17 + (sel_i mod 30). For Q, tap i is stage (sel_i mod 24).
- R6: On each accepted bit, Q stage 0 takes P's combining output in start-stop mode, or that output XOR the ciphertext bit in synchronous mode. The remaining Q stages shift up by one.
- R7: On each accepted bit, key_bit toggles if and only if Q's combining output is 1. The new value appears in the next cycle.
- R8: A cycle with bit_valid low and no load changes neither the registers nor key_bit.
- R9: A decrypting instance with the same fill and mode, fed the ciphertext, outputs the original plaintext in both modes.
- R10: mode_sel (0 start-stop, 1 synchronous) and decrypt_sel (0 encrypt, 1 decrypt) are sampled only during a load. Changing them at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Load fill_in, the mode and the direction this cycle |
| fill_in | input | 115 | Register contents and tap selectors |
| mode_sel | input | 1 | 0 start-stop, 1 synchronous (sampled at load) |
| decrypt_sel | input | 1 | 0 encrypt, 1 decrypt (sampled at load) |
| bit_valid | input | 1 | bit_in carries a data bit this cycle |
| bit_in | input | 1 | Plaintext (encrypt) or ciphertext (decrypt) bit |
| bit_out | output | 1 | bit_in XOR key_bit, combinational |
| key_bit | output | 1 | Integrator state, the current key bit |

## Verification
bit_out is combinational from bit_in and the registered key, so it is due in the same cycle as the stimulus. The bench drives at the falling edge and samples one nanosecond later, before the next rising edge. key_bit and the register contents change at the rising edge after an accepted bit or a load, so the bench updates its reference model only after that cycle's samples and compares key_bit at the next falling edge. A load is checked at the falling edge following its rising edge, where key_bit must already read 0.

// File: rtl/kg_pkg.sv
`timescale 1ns/1ps
package kg_pkg;

    typedef enum logic {
        ST_BLANK = 1'b0,
        ST_KEYED = 1'b1
    } kg_state_e;

    typedef enum logic {
        MODE_START_STOP = 1'b0,
        MODE_SYNC       = 1'b1
    } kg_mode_e;

endpackage

// File: rtl/kg_preg.sv
`timescale 1ns/1ps
module kg_preg #(
    parameter int MAIN_LEN = 30,
    parameter int EXT_LEN  = 17,
    parameter int N_TAPS   = 4,
    parameter int SEL_W    = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic [MAIN_LEN+EXT_LEN-1:0]  init,
    input  logic [N_TAPS*SEL_W-1:0]      tap_sel,
    input  logic                         mode_sync,
    input  logic                         step,
    input  logic                         c_bit,
    output logic                         comb_out
);
    localparam int LEN   = MAIN_LEN + EXT_LEN;
    localparam int IDX_W = $clog2(LEN);
    localparam int PAIRS = N_TAPS / 2;

    logic [LEN-1:0]          p_q;
    logic [N_TAPS*SEL_W-1:0] sel_q;
    logic [N_TAPS-1:0]       tap_val;
    logic [PAIRS-1:0]        pair_and;

    // one chain; the low EXT_LEN stages form the extension in sync mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q   <= '0;
            sel_q <= '0;
        end else if (load_en) begin
            p_q   <= init;
            sel_q <= tap_sel;
        end else if (step) begin
            p_q <= {p_q[LEN-2:0], c_bit};
        end
    end

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        logic [SEL_W-1:0] sel;
        logic [IDX_W-1:0] idx_full;
        logic [IDX_W-1:0] idx_main;
        assign sel      = sel_q[i*SEL_W +: SEL_W];
        assign idx_full = IDX_W'(int'(sel) % LEN);
        assign idx_main = IDX_W'(EXT_LEN + (int'(sel) % MAIN_LEN));
        assign tap_val[i] = mode_sync ? p_q[idx_main] : p_q[idx_full];
    end

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        assign pair_and[j] = tap_val[2*j] & tap_val[2*j+1];
    end

    assign comb_out = |pair_and;

    // R4
    p_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en) |=> (p_q[0] == $past(c_bit)) &&
                               (p_q[LEN-1:1] == $past(p_q[LEN-2:0])));

    // R8
    p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_en) |=> $stable(p_q) && $stable(sel_q));

endmodule

// File: rtl/kg_qreg.sv
`timescale 1ns/1ps
module kg_qreg #(
    parameter int LEN    = 24,
    parameter int N_TAPS = 4,
    parameter int SEL_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [LEN-1:0]          init,
    input  logic [N_TAPS*SEL_W-1:0] tap_sel,
    input  logic                    step,
    input  logic                    feed,
    output logic                    comb_out
);
    localparam int IDX_W = $clog2(LEN);
    localparam int PAIRS = N_TAPS / 2;

    logic [LEN-1:0]          q_q;
    logic [N_TAPS*SEL_W-1:0] sel_q;
    logic [N_TAPS-1:0]       tap_val;
    logic [PAIRS-1:0]        pair_and;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q   <= '0;
            sel_q <= '0;
        end else if (load_en) begin
            q_q   <= init;
            sel_q <= tap_sel;
        end else if (step) begin
            q_q <= {q_q[LEN-2:0], feed};
        end
    end

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        logic [IDX_W-1:0] idx;
        assign idx        = IDX_W'(int'(sel_q[i*SEL_W +: SEL_W]) % LEN);
        assign tap_val[i] = q_q[idx];
    end

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        assign pair_and[j] = tap_val[2*j] & tap_val[2*j+1];
    end

    assign comb_out = |pair_and;

    // R6
    q_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en) |=> (q_q[0] == $past(feed)) &&
                               (q_q[LEN-1:1] == $past(q_q[LEN-2:0])));

    // R8
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_en) |=> $stable(q_q));

endmodule

// File: rtl/kg_ctrl.sv
`timescale 1ns/1ps
module kg_ctrl
    import kg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic mode_sel,
    input  logic decrypt_sel,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic p_comb,
    input  logic q_comb,
    output logic step,
    output logic mode_sync,
    output logic c_bit,
    output logic q_feed,
    output logic bit_out,
    output logic key_bit
);
    kg_state_e state_q, state_d;
    kg_mode_e  mode_q;
    logic      dec_q;
    logic      key_q;

    // next state: FILL from any state, otherwise hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (load_en) state_d = ST_KEYED;
            ST_KEYED: state_d = ST_KEYED;
            default:  state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    // latched configuration and the toggle integrator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_START_STOP;
            dec_q  <= 1'b0;
            key_q  <= 1'b0;
        end else if (load_en) begin
            mode_q <= kg_mode_e'(mode_sel);
            dec_q  <= decrypt_sel;
            key_q  <= 1'b0;
        end else if (step) begin
            key_q <= key_q ^ q_comb;
        end
    end

    // outputs per state
    always_comb begin
        step    = 1'b0;
        bit_out = bit_in;
        c_bit   = bit_in;
        unique case (state_q)
            ST_BLANK: begin
                step    = 1'b0;
                bit_out = bit_in;
                c_bit   = bit_in;
            end
            ST_KEYED: begin
                step    = bit_valid && !load_en;
                bit_out = bit_in ^ key_q;
                c_bit   = dec_q ? bit_in : (bit_in ^ key_q);
            end
            default: begin
                step    = 1'b0;
                bit_out = bit_in;
                c_bit   = bit_in;
            end
        endcase
    end

    assign mode_sync = (mode_q == MODE_SYNC);
    assign q_feed    = mode_sync ? (p_comb ^ c_bit) : p_comb;
    assign key_bit   = key_q;

    // R2
    key_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (key_q == 1'b0));

    // R8
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !bit_valid) |=> $stable(key_q));

    // R1
    blank_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK) |-> (key_q == 1'b0) && (bit_out == bit_in));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(mode_q) && $stable(dec_q));

endmodule

// File: rtl/feedback_keystream_gen.sv
`timescale 1ns/1ps
module feedback_keystream_gen
    import kg_pkg::*;
#(
    parameter int P_MAIN_LEN = 30,
    parameter int P_EXT_LEN  = 17,
    parameter int Q_LEN      = 24,
    parameter int N_TAPS     = 4,
    parameter int P_SEL_W    = 6,
    parameter int Q_SEL_W    = 5,
    localparam int P_LEN     = P_MAIN_LEN + P_EXT_LEN,
    localparam int FILL_W    = P_LEN + Q_LEN + N_TAPS * (P_SEL_W + Q_SEL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [FILL_W-1:0] fill_in,
    input  logic              mode_sel,
    input  logic              decrypt_sel,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              bit_out,
    output logic              key_bit
);
    localparam int Q_OFS  = P_LEN;
    localparam int PS_OFS = Q_OFS + Q_LEN;
    localparam int QS_OFS = PS_OFS + N_TAPS * P_SEL_W;

    logic step, mode_sync, c_bit, q_feed, p_comb, q_comb;

    kg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .mode_sel    (mode_sel),
        .decrypt_sel (decrypt_sel),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .p_comb      (p_comb),
        .q_comb      (q_comb),
        .step        (step),
        .mode_sync   (mode_sync),
        .c_bit       (c_bit),
        .q_feed      (q_feed),
        .bit_out     (bit_out),
        .key_bit     (key_bit)
    );

    kg_preg #(
        .MAIN_LEN (P_MAIN_LEN),
        .EXT_LEN  (P_EXT_LEN),
        .N_TAPS   (N_TAPS),
        .SEL_W    (P_SEL_W)
    ) u_preg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .init      (fill_in[P_LEN-1:0]),
        .tap_sel   (fill_in[PS_OFS +: N_TAPS*P_SEL_W]),
        .mode_sync (mode_sync),
        .step      (step),
        .c_bit     (c_bit),
        .comb_out  (p_comb)
    );

    kg_qreg #(
        .LEN    (Q_LEN),
        .N_TAPS (N_TAPS),
        .SEL_W  (Q_SEL_W)
    ) u_qreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .init     (fill_in[Q_OFS +: Q_LEN]),
        .tap_sel  (fill_in[QS_OFS +: N_TAPS*Q_SEL_W]),
        .step     (step),
        .feed     (q_feed),
        .comb_out (q_comb)
    );

endmodule

// File: tb/tb_feedback_keystream_gen.sv
`timescale 1ns/1ps
module tb_feedback_keystream_gen;

    localparam int FW = 115;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [FW-1:0] fill = '0;
    logic          mode_sel = 1'b0;
    logic          enc_role = 1'b0;
    logic          dec_role = 1'b1;
    logic          e_valid = 1'b0;
    logic          e_in = 1'b0;
    logic          e_out, e_key, d_out, d_key;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    feedback_keystream_gen dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .fill_in(fill),
        .mode_sel(mode_sel), .decrypt_sel(enc_role), .bit_valid(e_valid),
        .bit_in(e_in), .bit_out(e_out), .key_bit(e_key));

    feedback_keystream_gen dec (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .fill_in(fill),
        .mode_sel(mode_sel), .decrypt_sel(dec_role), .bit_valid(e_valid),
        .bit_in(e_out), .bit_out(d_out), .key_bit(d_key));

    // reference model built from the requirements
    logic [46:0] mp;
    logic [23:0] mq;
    logic        mkey;
    logic        mmode;
    logic [5:0]  mps [4];
    logic [4:0]  mqs [4];

    task automatic model_load(input logic [FW-1:0] f, input logic m);
        mp = f[46:0];
        mq = f[70:47];
        for (int i = 0; i < 4; i++) begin
            mps[i] = f[71 + 6*i +: 6];
            mqs[i] = f[95 + 5*i +: 5];
        end
        mkey  = 1'b0;
        mmode = m;
    endtask

    task automatic model_step(input logic c);
        logic [3:0] pt, qt;
        logic pf, qf;
        for (int i = 0; i < 4; i++) begin
            pt[i] = mmode ? mp[17 + (int'(mps[i]) % 30)] : mp[int'(mps[i]) % 47];
            qt[i] = mq[int'(mqs[i]) % 24];
        end
        pf = (pt[0] & pt[1]) | (pt[2] & pt[3]);
        qf = (qt[0] & qt[1]) | (qt[2] & qt[3]);
        mkey = mkey ^ qf;
        mq = {mq[22:0], mmode ? (pf ^ c) : pf};
        mp = {mp[45:0], c};
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic send_bit(input logic pt, input logic v, input string tag);
        logic ct;
        e_valid = v;
        e_in    = pt;
        #1;
        ct = pt ^ mkey;
        chk({tag, " key_bit"}, e_key, mkey);
        chk("R3 ciphertext", e_out, ct);
        chk("R9 recovered plaintext", d_out, pt);
        if (v) model_step(ct);
        @(negedge clk);
        e_valid = 1'b0;
    endtask

    task automatic do_load(input logic [FW-1:0] f, input logic m, input logic with_bit);
        load_en  = 1'b1;
        fill     = f;
        mode_sel = m;
        e_valid  = with_bit;
        e_in     = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        e_valid = 1'b0;
        model_load(f, m);
        chk("R2 key cleared (enc)", e_key, 1'b0);
        chk("R2 key cleared (dec)", d_key, 1'b0);
    endtask

    task automatic stream(input int nchar, input int mul, input string tag);
        for (int k = 0; k < nchar; k++) begin
            logic [4:0] ch;
            ch = 5'((k * mul + 3) % 32);
            for (int b = 0; b < 5; b++) send_bit(ch[b], 1'b1, tag);
        end
    endtask

    localparam logic [FW-1:0] FILL_A = {5'd3, 5'd11, 5'd19, 5'd30,
                                        6'd5, 6'd21, 6'd40, 6'd9,
                                        24'hA5C31E, 47'h1A3C_96E1_7B2D};
    localparam logic [FW-1:0] FILL_B = {5'd31, 5'd24, 5'd7, 5'd28,
                                        6'd63, 6'd47, 6'd52, 6'd33,
                                        24'h3F0C81, 47'h7E01_55AA_C3F0};

    task automatic t_reset();
        chk("R1 key after reset", e_key, 1'b0);
        for (int k = 0; k < 6; k++) begin
            e_valid = 1'b1;
            e_in    = k[0];
            #1;
            chk("R1 pass-through when blank", e_out, k[0]);
            @(negedge clk);
        end
        e_valid = 1'b0;
        chk("R1 key still zero", e_key, 1'b0);
    endtask

    task automatic t_start_stop();
        do_load(FILL_A, 1'b0, 1'b0);
        stream(40, 7, "R4 R5 R7 start-stop");
        do_load(FILL_B, 1'b0, 1'b0);
        stream(40, 13, "R5 tap wrap start-stop");
    endtask

    task automatic t_sync();
        do_load(FILL_A, 1'b1, 1'b0);
        stream(40, 11, "R6 R5 sync");
        do_load(FILL_B, 1'b1, 1'b0);
        stream(40, 5, "R5 tap wrap sync");
    endtask

    task automatic t_gaps();
        do_load(FILL_B, 1'b1, 1'b0);
        for (int k = 0; k < 60; k++) send_bit(k[1] ^ k[3], (k % 3) != 0, "R8 gap");
    endtask

    task automatic t_reload();
        do_load(FILL_A, 1'b0, 1'b0);
        stream(6, 9, "R7 before reload");
        do_load(FILL_A, 1'b0, 1'b1);
        stream(20, 9, "R2 after reload with dropped bit");
    endtask

    task automatic t_cfg_ignored();
        do_load(FILL_B, 1'b0, 1'b0);
        mode_sel = 1'b1;
        enc_role = 1'b1;
        dec_role = 1'b0;
        stream(30, 17, "R10 config change ignored");
        mode_sel = 1'b0;
        enc_role = 1'b0;
        dec_role = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_stop();
        t_sync();
        t_gaps();
        t_reload();
        t_cfg_ignored();
        finish_run();
    end

endmodule